// File: doc/BRIEF.md
# Synchronous Byte Serial Shift Port

This block is a byte-wide synchronous serial port for a microcontroller. Software loads an 8-bit data register and then sets a start bit in a mode register. On each falling edge of the shift clock the port drives one bit onto the serial output. On each rising edge it samples one bit from the serial input into the same register. After eight bits the register holds the received byte, the start bit clears itself and a completion flag is set. When the interrupt enable is on, that flag raises an interrupt. The flag stays set until software clears it.

The shift clock is either internal or external. An internal clock comes from a free-running divider with three selectable ratios, and the port can drive it out on the clock pin. An external clock enters on the clock pin and is synchronised into the system clock domain, where its edges are detected. Because the divider runs freely and the external clock is not under the port's control, a start is not aligned to the shift clock. The first bit can appear up to one shift-clock period after start is set. Between transfers the shift clock rests high.

The port has no streaming data path. Both registers are written through plain write strobes and read back continuously, so no back-pressure applies. Software must leave the configuration alone while a transfer runs, and the port enforces this: during a transfer it ignores data writes and mode fields other than start and the flag.

Top module: `sshift_port`

## Requirements
- R1: After reset the mode register and data register read 0, `irq` is 0, `sck_oe` is 0, and both `sck_o` and `so` are 1.
- R2: A transfer runs only while start is set. After the eighth rising shift-clock edge, start reads 0, the completion flag (mode bit 7) reads 1, and the data register holds the eight received bits.
- R3: Mode bit 5 selects the bit order: 0 sends and receives the MSB first, 1 sends and receives the LSB first.
- R4: Clock select is mode bits 4:3. Code 11 selects the external clock on `sck_i`, and with it `sck_oe` stays 0 and `sck_o` stays 1. Codes 00, 01 and 10 select the internal clock, and `sck_oe` then follows the clock-output enable (mode bit 2).
- R5: `so` changes only after a falling shift-clock edge and holds its value across the rising edge, at which `si` is sampled.
- R6: `sck_o` is 1 whenever start is 0. It is also 1 from start until the first internal falling edge, and it returns to 1 after the eighth bit.
- R7: While stopped with the serial output enabled (mode bit 1), `so` shows the first bit to be sent, which is data bit 7 with MSB first or bit 0 with LSB first. With mode bit 1 at 0, `so` is 1.
- R8: If a mode write that clears start lands in the same cycle as the eighth rising edge, the completion flag is not set. If the same write lands one cycle later, the flag is set.
- R9: `irq` is 1 while both the flag and the interrupt enable (mode bit 6) are 1. The flag holds until a mode write carries 0 in bit 7. Writing 1 to bit 7 leaves the flag unchanged, and software cannot set it.
- R10: While start is 1, data-register writes are ignored, and mode writes change only start and the flag.
- R11: Clearing start in the middle of a transfer stops it at once and leaves the flag at 0.
- R12: Clock-select codes 00, 01 and 10 give internal half-periods of HALF0, HALF1 and HALF2 system cycles (defaults 2, 4 and 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode write value: 0 start, 1 output enable, 2 clock output enable, 4:3 clock select, 5 LSB first, 6 interrupt enable, 7 flag (write 0 to clear) |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | 8 | Data register write value |
| mode_rdata | output | 8 | Current mode register |
| data_rdata | output | 8 | Current data/shift register |
| irq | output | 1 | Completion interrupt request |
| sck_i | input | 1 | External shift clock |
| sck_o | output | 1 | Shift clock driven out |
| sck_oe | output | 1 | Drive enable for the clock pin |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |

## Verification
Two events can land in the same cycle: the completion of the eighth bit and a software write that clears start. The bench drives the external clock itself, so it knows the cycle in which the synchronised rising edge takes effect. It places the stop write exactly in that cycle and expects the flag to stay 0 with start cleared. It then repeats the transfer with the write one cycle later and expects the flag to be set. The scoreboard must see that late completion and must not see the suppressed one.

// File: rtl/sshift_pkg.sv
package sshift_pkg;
  localparam int BYTE_W = 8;
  localparam logic [1:0] CKSEL_EXT = 2'b11;

  typedef enum logic [1:0] {
    SH_IDLE,
    SH_ARMED,
    SH_RUN
  } sh_state_e;

  // Mode register layout, bit 7 down to bit 0
  typedef struct packed {
    logic       done;
    logic       irq_en;
    logic       lsb_first;
    logic [1:0] ck_sel;
    logic       sck_oe;
    logic       so_en;
    logic       start;
  } mode_t;
endpackage

// File: rtl/sshift_divider.sv
module sshift_divider #(
  parameter int HALF0 = 2,
  parameter int HALF1 = 4,
  parameter int HALF2 = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output logic       phase,
  output logic       fall_ev,
  output logic       rise_ev
);
  localparam int H01  = (HALF0 > HALF1) ? HALF0 : HALF1;
  localparam int HMAX = (H01 > HALF2) ? H01 : HALF2;
  localparam int CW   = $clog2(HMAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          wrap;

  always_comb begin
    case (sel)
      2'd0:    limit = CW'(HALF0 - 1);
      2'd1:    limit = CW'(HALF1 - 1);
      default: limit = CW'(HALF2 - 1);
    endcase
  end

  assign wrap    = (cnt >= limit);
  assign fall_ev = wrap & phase;
  assign rise_ev = wrap & ~phase;

  // Free running: a start is never aligned to this clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b1;
    end else if (wrap) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sshift_sync.sv
module sshift_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_ev,
  output logic fall_ev
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], async_in};
  end

  assign rise_ev = chain[STAGES-1] & ~chain[STAGES];
  assign fall_ev = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/sshift_engine.sv
module sshift_engine
  import sshift_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         lsb_first,
  input  logic         fall_ev,
  input  logic         rise_ev,
  input  logic         si,
  input  logic         load_en,
  input  logic [W-1:0] load_data,
  output logic [W-1:0] sr,
  output logic         so_bit,
  output logic         running,
  output logic         complete
);
  localparam int CW = $clog2(W);

  sh_state_e     state;
  logic [CW-1:0] cnt;
  logic          head;
  logic [W-1:0]  shifted;

  assign head    = lsb_first ? sr[0] : sr[W-1];
  assign shifted = lsb_first ? {si, sr[W-1:1]} : {sr[W-2:0], si};
  assign running = (state == SH_RUN);
  assign complete = running & start & rise_ev & (cnt == CW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SH_IDLE;
      sr     <= '0;
      cnt    <= '0;
      so_bit <= 1'b1;
    end else begin
      case (state)
        SH_IDLE: begin
          so_bit <= head;
          if (load_en) sr <= load_data;
          if (start) state <= SH_ARMED;
        end
        SH_ARMED: begin
          if (!start) begin
            so_bit <= head;
            state  <= SH_IDLE;
          end else if (fall_ev) begin
            so_bit <= head;
            cnt    <= '0;
            state  <= SH_RUN;
          end
        end
        default: begin
          if (!start) begin
            so_bit <= head;
            state  <= SH_IDLE;
          end else begin
            if (fall_ev) so_bit <= head;
            if (rise_ev) begin
              sr <= shifted;
              if (cnt == CW'(W - 1)) state <= SH_IDLE;
              else                   cnt   <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sshift_port.sv
module sshift_port
  import sshift_pkg::*;
#(
  parameter int HALF0       = 2,
  parameter int HALF1       = 4,
  parameter int HALF2       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic [7:0] mode_wdata,
  input  logic       data_we,
  input  logic [7:0] data_wdata,
  output logic [7:0] mode_rdata,
  output logic [7:0] data_rdata,
  output logic       irq,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       si,
  output logic       so
);
  mode_t mode_q;
  mode_t wr;
  logic  ext_sel;
  logic  div_phase, div_fall, div_rise;
  logic  x_rise, x_fall;
  logic  fall_ev, rise_ev;
  logic  so_bit, running, complete;
  logic  stop_req, done_set;
  logic [BYTE_W-1:0] sr;

  assign wr      = mode_t'(mode_wdata);
  assign ext_sel = (mode_q.ck_sel == CKSEL_EXT);

  sshift_divider #(.HALF0(HALF0), .HALF1(HALF1), .HALF2(HALF2)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (mode_q.ck_sel),
    .phase   (div_phase),
    .fall_ev (div_fall),
    .rise_ev (div_rise)
  );

  sshift_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (sck_i),
    .rise_ev  (x_rise),
    .fall_ev  (x_fall)
  );

  assign fall_ev = ext_sel ? x_fall : div_fall;
  assign rise_ev = ext_sel ? x_rise : div_rise;

  sshift_engine #(.W(BYTE_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (mode_q.start),
    .lsb_first (mode_q.lsb_first),
    .fall_ev   (fall_ev),
    .rise_ev   (rise_ev),
    .si        (si),
    .load_en   (data_we & ~mode_q.start),
    .load_data (data_wdata),
    .sr        (sr),
    .so_bit    (so_bit),
    .running   (running),
    .complete  (complete)
  );

  // A stop landing on the completing edge suppresses the flag
  assign stop_req = mode_we & ~wr.start;
  assign done_set = complete & ~stop_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else begin
      if (complete)     mode_q.start <= 1'b0;
      else if (mode_we) mode_q.start <= wr.start;

      if (mode_we && !mode_q.start) begin
        mode_q.so_en     <= wr.so_en;
        mode_q.sck_oe    <= wr.sck_oe;
        mode_q.ck_sel    <= wr.ck_sel;
        mode_q.lsb_first <= wr.lsb_first;
        mode_q.irq_en    <= wr.irq_en;
      end

      if (done_set)                 mode_q.done <= 1'b1;
      else if (mode_we && !wr.done) mode_q.done <= 1'b0;
    end
  end

  assign mode_rdata = mode_q;
  assign data_rdata = sr;
  assign irq        = mode_q.done & mode_q.irq_en;
  assign sck_oe     = mode_q.sck_oe & ~ext_sel;
  assign sck_o      = (!ext_sel && running && mode_q.start) ? div_phase : 1'b1;
  assign so         = mode_q.so_en ? so_bit : 1'b1;
endmodule

// File: rtl/sshift_port_chk.sv
module sshift_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_we,
  input logic       data_we,
  input logic [7:0] mode_rdata,
  input logic [7:0] data_rdata,
  input logic       irq,
  input logic       sck_o,
  input logic       sck_oe,
  input logic       so
);
  // R6
  sck_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_rdata[0] |-> sck_o);

  // R4
  ext_clk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rdata[4:3] == 2'b11) |-> (sck_o && !sck_oe));

  // R2
  flag_from_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_rdata[7]) |-> $past(mode_rdata[0]));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_rdata[7]) && !$past(mode_we)) |-> mode_rdata[7]);

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> mode_rdata[7]);

  // R10
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rdata[0] && $past(mode_rdata[0])) |-> $stable(mode_rdata[6:1]));

  // R7
  so_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_rdata[0] && mode_rdata[1] && !mode_we && !data_we)
      |=> (so == (mode_rdata[5] ? data_rdata[0] : data_rdata[7])));
endmodule

bind sshift_port sshift_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_we    (mode_we),
  .data_we    (data_we),
  .mode_rdata (mode_rdata),
  .data_rdata (data_rdata),
  .irq        (irq),
  .sck_o      (sck_o),
  .sck_oe     (sck_oe),
  .so         (so)
);

// File: tb/tb_sshift_port.sv
module tb_sshift_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_we = 1'b0;
  logic [7:0] mode_wdata = '0;
  logic       data_we = 1'b0;
  logic [7:0] data_wdata = '0;
  logic [7:0] mode_rdata, data_rdata;
  logic       irq, sck_o, sck_oe, so, si;
  logic       sck_i = 1'b1;
  logic       si_drv = 1'b1;
  logic       loop = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  byte unsigned exp_q[$];
  byte unsigned exp_b;
  logic done_prev = 1'b0;

  always #5 clk = ~clk;
  assign si = loop ? so : si_drv;

  sshift_port dut (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .data_we(data_we), .data_wdata(data_wdata), .mode_rdata(mode_rdata),
    .data_rdata(data_rdata), .irq(irq), .sck_i(sck_i), .sck_o(sck_o),
    .sck_oe(sck_oe), .si(si), .so(so)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input bit st, input bit soe, input bit cko,
                                    input logic [1:0] sel, input bit lsb,
                                    input bit ie, input bit dn);
    return {dn, ie, lsb, sel, cko, soe, st};
  endfunction

  task automatic wr_mode(input logic [7:0] v);
    @(negedge clk); mode_we = 1'b1; mode_wdata = v;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic wr_data(input logic [7:0] v);
    @(negedge clk); data_we = 1'b1; data_wdata = v;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor: each flag rise pops one expected byte
  always @(negedge clk) begin
    if (rst_n) begin
      if (mode_rdata[7] && !done_prev) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 R2 unexpected completion", 1, 0);
        end else begin
          exp_b = exp_q.pop_front();
          check(data_rdata == exp_b, "R2 R3 received byte", data_rdata, exp_b);
        end
      end
      done_prev = mode_rdata[7];
    end
  end

  // Drive nbits external clock periods; so checked before and after each rise
  task automatic ext_bits(input logic [7:0] tx, input logic [7:0] rx,
                          input bit lsb, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      int idx;
      idx = lsb ? i : 7 - i;
      sck_i = 1'b0; si_drv = rx[idx];
      idle(8);
      check(so == tx[idx], "R5 R3 so after fall", so, tx[idx]);
      sck_i = 1'b1;
      idle(8);
      check(so == tx[idx], "R5 so held across rise", so, tx[idx]);
    end
  endtask

  task automatic int_xfer(input logic [1:0] sel, input bit lsb,
                          input logic [7:0] tx, input int half);
    int lw;
    int t;
    wr_data(tx);
    exp_q.push_back(tx);
    check(sck_o == 1'b1, "R6 sck high before start", sck_o, 1);
    wr_mode(mk(1, 1, 1, sel, lsb, 1, 1));
    check(sck_oe == 1'b1, "R4 internal clock drives pin", sck_oe, 1);
    t = 0;
    while (sck_o && t < 200) begin @(negedge clk); t++; end
    lw = 0;
    while (!sck_o && lw < 200) begin @(negedge clk); lw++; end
    check(lw == half, "R12 internal half period", lw, half);
    t = 0;
    while (!mode_rdata[7] && t < 2000) begin @(negedge clk); t++; end
    check(mode_rdata[0] == 1'b0, "R2 start self clears", mode_rdata[0], 0);
    check(irq == 1'b1, "R9 irq raised", irq, 1);
    check(sck_o == 1'b1, "R6 sck high after transfer", sck_o, 1);
    idle(20);
    check(mode_rdata[7] == 1'b1, "R9 flag holds", mode_rdata[7], 1);
    wr_mode(mk(0, 1, 1, sel, lsb, 1, 1));
    check(mode_rdata[7] == 1'b1, "R9 writing 1 keeps flag", mode_rdata[7], 1);
    wr_mode(mk(0, 1, 1, sel, lsb, 1, 0));
    check(irq == 1'b0 && mode_rdata[7] == 1'b0, "R9 flag cleared", irq, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1
    check(mode_rdata == 8'h00, "R1 mode reset", mode_rdata, 0);
    check(data_rdata == 8'h00, "R1 data reset", data_rdata, 0);
    check(irq == 1'b0 && sck_oe == 1'b0, "R1 irq/sck_oe reset", {irq, sck_oe}, 0);
    check(sck_o == 1'b1 && so == 1'b1, "R1 pins idle high", {sck_o, so}, 3);

    // R7 / R4: stopped, external clock
    wr_data(8'h2B);
    wr_mode(mk(0, 0, 1, 2'b11, 0, 0, 1));
    idle(2);
    check(so == 1'b1, "R7 so high when disabled", so, 1);
    check(sck_oe == 1'b0 && sck_o == 1'b1, "R4 external clock not driven", {sck_oe, sck_o}, 1);
    wr_mode(mk(0, 1, 1, 2'b11, 0, 0, 1));
    idle(2);
    check(so == 1'b0, "R7 so shows msb when stopped", so, 0);
    wr_mode(mk(0, 1, 1, 2'b11, 1, 0, 1));
    idle(2);
    check(so == 1'b1, "R7 so shows lsb when stopped", so, 1);

    // R3 / R5: external clock, LSB first then MSB first
    exp_q.push_back(8'hD4);
    wr_mode(mk(1, 1, 0, 2'b11, 1, 0, 1));
    idle(5);
    ext_bits(8'h2B, 8'hD4, 1'b1, 8);
    idle(3);
    check(mode_rdata[0] == 1'b0 && mode_rdata[7] == 1'b1, "R2 ext done", mode_rdata, 8'h80);
    wr_mode(mk(0, 1, 0, 2'b11, 0, 0, 0));
    wr_data(8'h96);
    exp_q.push_back(8'h3C);
    wr_mode(mk(1, 1, 0, 2'b11, 0, 0, 1));
    idle(3);
    ext_bits(8'h96, 8'h3C, 1'b0, 8);
    idle(3);
    wr_mode(mk(0, 1, 0, 2'b11, 0, 0, 0));

    // R10 / R11: writes ignored while running, then abort
    wr_data(8'h55);
    wr_mode(mk(1, 1, 0, 2'b11, 0, 0, 1));
    idle(2);
    wr_data(8'hFF);
    check(data_rdata == 8'h55, "R10 data write ignored", data_rdata, 8'h55);
    wr_mode(mk(1, 1, 0, 2'b11, 1, 1, 1));
    check(mode_rdata[6:5] == 2'b00, "R10 mode fields frozen", mode_rdata[6:5], 0);
    ext_bits(8'h55, 8'h00, 1'b0, 3);
    wr_mode(mk(0, 1, 0, 2'b11, 0, 0, 1));
    idle(20);
    check(mode_rdata[0] == 1'b0 && mode_rdata[7] == 1'b0, "R11 abort leaves flag clear", mode_rdata, 0);

    // R8: stop on the completing cycle
    wr_data(8'h00);
    wr_mode(mk(1, 1, 0, 2'b11, 0, 0, 1));
    idle(3);
    ext_bits(8'h00, 8'hA7, 1'b0, 7);
    sck_i = 1'b0; si_drv = 1'b1;
    idle(8);
    sck_i = 1'b1;
    idle(2);
    mode_we = 1'b1; mode_wdata = mk(0, 1, 0, 2'b11, 0, 0, 1);
    idle(1);
    mode_we = 1'b0;
    idle(10);
    check(mode_rdata[7] == 1'b0, "R8 coincident stop suppresses flag", mode_rdata[7], 0);
    check(mode_rdata[0] == 1'b0, "R8 start cleared", mode_rdata[0], 0);

    // R8: the same stop one cycle late
    wr_data(8'h00);
    exp_q.push_back(8'hA7);
    wr_mode(mk(1, 1, 0, 2'b11, 0, 0, 1));
    idle(3);
    ext_bits(8'h00, 8'hA7, 1'b0, 7);
    sck_i = 1'b0; si_drv = 1'b1;
    idle(8);
    sck_i = 1'b1;
    idle(3);
    mode_we = 1'b1; mode_wdata = mk(0, 1, 0, 2'b11, 0, 0, 1);
    idle(1);
    mode_we = 1'b0;
    idle(10);
    check(mode_rdata[7] == 1'b1, "R8 late stop keeps flag", mode_rdata[7], 1);
    wr_mode(mk(0, 1, 0, 2'b11, 0, 0, 0));

    // R12 / R2 / R9: internal clock with loopback
    loop = 1'b1;
    int_xfer(2'd0, 1'b0, 8'hC5, 2);
    int_xfer(2'd1, 1'b1, 8'h3A, 4);
    int_xfer(2'd2, 1'b0, 8'h69, 8);
    loop = 1'b0;
    idle(5);
    check(exp_q.size() == 0, "R2 all expected completions seen", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule